// File: doc/BRIEF.md
# Stuck-at-One Fault Detection Harness for a Gated 2:1 Multiplexer

This block keeps two copies of a gate-level 2:1 multiplexer. One copy is fault-free. The other has eight internal nets, and each of those nets can be pinned to logic 1 by its own bit in an 8-bit mask. The block compares the two outputs. A mismatch flag rises whenever the two outputs differ for the inputs currently applied. A fault that leaves the outputs equal for those inputs is not reported, even though it is present.

The harness works in two ways. While it is idle, any mask and any input pattern can be applied by hand, and both outputs and the mismatch flag follow combinationally. A start pulse launches an exhaustive sweep. The sweep takes each single-site fault in turn and applies all eight input patterns to it, one pattern per clock. It records which patterns exposed each fault, marks the faults that were exposed at least once and counts them. It ends with a one-cycle done pulse.

Top module: `saf1_mux_harness`

## Requirements
- R1: The fault-free output equals `man_i1` when `man_sel` is 1 and `man_i0` when `man_sel` is 0.
- R2: When the harness is idle, mask bit k forces one net of the faulty copy to 1. The bits map to nets as follows: bit 0 is the select line at the inverter input, bit 1 the select branch into the I1 AND gate, bit 2 the I0 input, bit 3 the I1 input, bit 4 the inverter output, bit 5 the I0 AND output, bit 6 the I1 AND output and bit 7 the OR output. `mismatch` is 1 exactly when `bad_y` differs from `good_y`.
- R3: With an all-zero mask, `bad_y` equals `good_y` and `mismatch` is 0 for every input pattern.
- R4: Any combination of mask bits may be set at once, and each set bit forces its own net.
- R5: While idle, a start sampled high makes `busy` 1 from the next edge. The sweep then evaluates 64 steps, one per clock. Step k applies the single fault on site k/8 and the input pattern p = k mod 8, where pattern bit 2 is the select, bit 1 is I1 and bit 0 is I0. During the sweep, `good_y` and `bad_y` show the step being evaluated.
- R6: After a sweep, bit 8·f+p of `pat_map` is 1 exactly when pattern p exposes the single fault on site f. Bit f of `fault_hit` is the OR of those eight bits.
- R7: `done` is a one-cycle pulse 64 edges after the edge that accepted start, and `busy` falls on that same edge.
- R8: `hit_count` equals the number of set bits in `fault_hit`. Every stuck-at-1 site of this circuit is exposed by some pattern, so a complete sweep yields 8.
- R9: A start raised while `busy` is 1 has no effect: the running sweep and its done timing are unchanged.
- R10: An accepted start clears `pat_map`, `fault_hit` and `hit_count` on the accepting edge. This includes a start raised in the cycle in which `done` is high.
- R11: After reset, `busy`, `done`, `pat_map`, `fault_hit` and `hit_count` are all 0.
- R12: With mask bit 7 set and the harness idle, `bad_y` is 1 for every input pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a sweep when sampled high while idle |
| man_mask | input | 8 | Manual fault mask, used while idle |
| man_sel | input | 1 | Manual select input |
| man_i1 | input | 1 | Manual data input 1 |
| man_i0 | input | 1 | Manual data input 0 |
| good_y | output | 1 | Fault-free multiplexer output |
| bad_y | output | 1 | Faulty-copy multiplexer output |
| mismatch | output | 1 | High when the two outputs differ |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at sweep end |
| fault_hit | output | 8 | Per-site exposed flag from the last sweep |
| pat_map | output | 64 | Exposing patterns, 8 bits per site, site f at bits 8f+7..8f |
| hit_count | output | 4 | Number of exposed sites |

## Verification
Two events can land in one cycle. The first case is a sweep's final step being recorded while a new start arrives. The bench waits for `done`, holds start high during that same cycle and then checks that the record is cleared on the accepting edge. It then checks that a second, identical map is rebuilt with its own single done pulse 64 edges later. The second case is a start raised in the middle of a sweep. That start must neither restart nor shift the sweep, and the bench judges this by the cycle on which `done` arrives and by the step-by-step outputs staying in order.

// File: rtl/saf_pkg.sv
package saf_pkg;

    localparam int NUM_SITES  = 8;
    localparam int PAT_BITS   = 3;
    localparam int NUM_PATS   = 1 << PAT_BITS;
    localparam int SITE_BITS  = $clog2(NUM_SITES);
    localparam int COUNT_BITS = $clog2(NUM_SITES + 1);
    localparam int MAP_BITS   = NUM_SITES * NUM_PATS;

    // Fault site positions inside the mask
    typedef enum int {
        SITE_SEL_INV = 0,
        SITE_SEL_AND = 1,
        SITE_IN0     = 2,
        SITE_IN1     = 3,
        SITE_SEL_N   = 4,
        SITE_AND0    = 5,
        SITE_AND1    = 6,
        SITE_OUT     = 7
    } site_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef logic [NUM_SITES-1:0] mask_t;
    typedef logic [PAT_BITS-1:0]  pat_t;
    typedef logic [SITE_BITS-1:0] site_t;

endpackage

// File: rtl/saf_mux_netlist.sv
module saf_mux_netlist
    import saf_pkg::*;
(
    input  logic  sel,
    input  logic  in1,
    input  logic  in0,
    input  mask_t force_one,
    output logic  y
);

    logic sel_inv_in;
    logic sel_and_in;
    logic in0_net;
    logic in1_net;
    logic sel_n_net;
    logic and0_net;
    logic and1_net;

    // Each net is the driven value ORed with its force bit
    always_comb begin
        sel_inv_in = sel | force_one[SITE_SEL_INV];
        sel_and_in = sel | force_one[SITE_SEL_AND];
        in0_net    = in0 | force_one[SITE_IN0];
        in1_net    = in1 | force_one[SITE_IN1];
        sel_n_net  = (~sel_inv_in) | force_one[SITE_SEL_N];
        and0_net   = (in0_net & sel_n_net) | force_one[SITE_AND0];
        and1_net   = (in1_net & sel_and_in) | force_one[SITE_AND1];
        y          = (and0_net | and1_net) | force_one[SITE_OUT];
    end

endmodule

// File: rtl/saf_sweep_seq.sv
module saf_sweep_seq
    import saf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    output logic  running,
    output logic  accept,
    output logic  done,
    output site_t cur_site,
    output pat_t  cur_pat,
    output mask_t cur_mask
);

    localparam site_t LAST_SITE = site_t'(NUM_SITES - 1);
    localparam pat_t  LAST_PAT  = pat_t'(NUM_PATS - 1);

    typedef struct packed {
        seq_state_e state;
        site_t      site;
        pat_t       pat;
        logic       done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        accept     = 1'b0;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    accept      = 1'b1;
                    seq_d.state = SEQ_RUN;
                    seq_d.site  = '0;
                    seq_d.pat   = '0;
                end
            end
            SEQ_RUN: begin
                if (seq_q.pat == LAST_PAT) begin
                    seq_d.pat = '0;
                    if (seq_q.site == LAST_SITE) begin
                        seq_d.state = SEQ_IDLE;
                        seq_d.site  = '0;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.site = seq_q.site + site_t'(1);
                    end
                end else begin
                    seq_d.pat = seq_q.pat + pat_t'(1);
                end
            end
            default: seq_d = seq_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_IDLE, site: '0, pat: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        running  = (seq_q.state == SEQ_RUN);
        done     = seq_q.done;
        cur_site = seq_q.site;
        cur_pat  = seq_q.pat;
        cur_mask = mask_t'(1) << seq_q.site;
    end

endmodule

// File: rtl/saf_detect_map.sv
module saf_detect_map
    import saf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  record,
    input  site_t                 site,
    input  pat_t                  pat,
    input  logic                  exposed,
    output logic [MAP_BITS-1:0]   map_flat,
    output mask_t                 site_hit,
    output logic [COUNT_BITS-1:0] hit_total
);

    typedef struct packed {
        logic [NUM_SITES-1:0][NUM_PATS-1:0] map;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (clear) begin
            rec_d.map = '0;
        end else if (record && exposed) begin
            rec_d.map[site][pat] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    for (genvar f = 0; f < NUM_SITES; f++) begin : g_site
        assign site_hit[f] = |rec_q.map[f];
        assign map_flat[f*NUM_PATS +: NUM_PATS] = rec_q.map[f];
    end

    always_comb begin
        hit_total = '0;
        for (int f = 0; f < NUM_SITES; f++) begin
            hit_total = hit_total + COUNT_BITS'(site_hit[f]);
        end
    end

endmodule

// File: rtl/saf1_mux_harness.sv
module saf1_mux_harness
    import saf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [NUM_SITES-1:0]  man_mask,
    input  logic                  man_sel,
    input  logic                  man_i1,
    input  logic                  man_i0,
    output logic                  good_y,
    output logic                  bad_y,
    output logic                  mismatch,
    output logic                  busy,
    output logic                  done,
    output logic [NUM_SITES-1:0]  fault_hit,
    output logic [MAP_BITS-1:0]   pat_map,
    output logic [COUNT_BITS-1:0] hit_count
);

    logic  running;
    logic  accept;
    site_t seq_site;
    pat_t  seq_pat;
    mask_t seq_mask;
    mask_t apply_mask;
    logic  apply_sel;
    logic  apply_i1;
    logic  apply_i0;

    saf_sweep_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .running  (running),
        .accept   (accept),
        .done     (done),
        .cur_site (seq_site),
        .cur_pat  (seq_pat),
        .cur_mask (seq_mask)
    );

    always_comb begin
        if (running) begin
            apply_mask = seq_mask;
            apply_sel  = seq_pat[2];
            apply_i1   = seq_pat[1];
            apply_i0   = seq_pat[0];
        end else begin
            apply_mask = man_mask;
            apply_sel  = man_sel;
            apply_i1   = man_i1;
            apply_i0   = man_i0;
        end
    end

    saf_mux_netlist u_golden (
        .sel       (apply_sel),
        .in1       (apply_i1),
        .in0       (apply_i0),
        .force_one ('0),
        .y         (good_y)
    );

    saf_mux_netlist u_faulty (
        .sel       (apply_sel),
        .in1       (apply_i1),
        .in0       (apply_i0),
        .force_one (apply_mask),
        .y         (bad_y)
    );

    assign mismatch = good_y ^ bad_y;
    assign busy     = running;

    saf_detect_map u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .record    (running),
        .site      (seq_site),
        .pat       (seq_pat),
        .exposed   (mismatch),
        .map_flat  (pat_map),
        .site_hit  (fault_hit),
        .hit_total (hit_count)
    );

endmodule

// File: rtl/saf1_mux_harness_chk.sv
module saf1_mux_harness_chk
    import saf_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_SITES-1:0]  man_mask,
    input logic                  man_sel,
    input logic                  man_i1,
    input logic                  man_i0,
    input logic                  good_y,
    input logic                  bad_y,
    input logic                  mismatch,
    input logic                  busy,
    input logic                  done,
    input logic [NUM_SITES-1:0]  fault_hit,
    input logic [COUNT_BITS-1:0] hit_count
);

    AST_GOLDEN_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> good_y == (man_sel ? man_i1 : man_i0)); // R1

    AST_CLEAN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && man_mask == '0) |-> !mismatch); // R3

    AST_OUT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && man_mask[NUM_SITES-1]) |-> bad_y); // R12

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R7

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (hit_count == '0 && fault_hit == '0)); // R10

    AST_COUNT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> hit_count >= $past(hit_count)); // R8

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count <= COUNT_BITS'(NUM_SITES)); // R8

endmodule

bind saf1_mux_harness saf1_mux_harness_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .man_mask  (man_mask),
    .man_sel   (man_sel),
    .man_i1    (man_i1),
    .man_i0    (man_i0),
    .good_y    (good_y),
    .bad_y     (bad_y),
    .mismatch  (mismatch),
    .busy      (busy),
    .done      (done),
    .fault_hit (fault_hit),
    .hit_count (hit_count)
);

// File: tb/saf1_mux_harness_bench.sv
module saf1_mux_harness_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  man_mask = '0;
    logic        man_sel = 1'b0;
    logic        man_i1 = 1'b0;
    logic        man_i0 = 1'b0;
    logic        good_y, bad_y, mismatch, busy, done;
    logic [7:0]  fault_hit;
    logic [63:0] pat_map;
    logic [3:0]  hit_count;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    saf1_mux_harness u_saf1_mux_harness (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .man_mask  (man_mask),
        .man_sel   (man_sel),
        .man_i1    (man_i1),
        .man_i0    (man_i0),
        .good_y    (good_y),
        .bad_y     (bad_y),
        .mismatch  (mismatch),
        .busy      (busy),
        .done      (done),
        .fault_hit (fault_hit),
        .pat_map   (pat_map),
        .hit_count (hit_count)
    );

    // Behavioural model with forced nets; pattern bits {S,I1,I0}
    function automatic bit model_y(input logic [7:0] m, input int p);
        bit s, i1, i0, sa, sb, a0, a1, n, g0, g1;
        s  = p[2]; i1 = p[1]; i0 = p[0];
        sa = m[0] ? 1'b1 : s;
        sb = m[1] ? 1'b1 : s;
        a0 = m[2] ? 1'b1 : i0;
        a1 = m[3] ? 1'b1 : i1;
        n  = m[4] ? 1'b1 : !sa;
        g0 = m[5] ? 1'b1 : (a0 && n);
        g1 = m[6] ? 1'b1 : (a1 && sb);
        return m[7] ? 1'b1 : (g0 || g1);
    endfunction

    function automatic bit ref_y(input int p);
        return p[2] ? p[1] : p[0];
    endfunction

    function automatic logic [63:0] expected_map();
        logic [63:0] e = '0;
        for (int f = 0; f < 8; f++)
            for (int p = 0; p < 8; p++)
                e[f*8+p] = (model_y(8'(1 << f), p) != ref_y(p));
        return e;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    task automatic apply_manual(input logic [7:0] m, input int p);
        man_mask = m;
        man_sel  = p[2];
        man_i1   = p[1];
        man_i0   = p[0];
        #1;
    endtask

    task automatic t_reset();
        check("R11 busy", 64'(busy), 64'd0);
        check("R11 done", 64'(done), 64'd0);
        check("R11 map", pat_map, 64'd0);
        check("R11 hit", 64'(fault_hit), 64'd0);
        check("R11 count", 64'(hit_count), 64'd0);
    endtask

    task automatic t_clean();
        for (int p = 0; p < 8; p++) begin
            apply_manual(8'h00, p);
            check("R1 good_y", 64'(good_y), 64'(ref_y(p)));
            check("R3 bad_y", 64'(bad_y), 64'(ref_y(p)));
            check("R3 mismatch", 64'(mismatch), 64'd0);
        end
    endtask

    task automatic t_single();
        for (int f = 0; f < 8; f++)
            for (int p = 0; p < 8; p++) begin
                apply_manual(8'(1 << f), p);
                check("R2 bad_y", 64'(bad_y), 64'(model_y(8'(1 << f), p)));
                check("R2 mismatch", 64'(mismatch), 64'(model_y(8'(1 << f), p) != ref_y(p)));
                if (f == 7) check("R12 out forced", 64'(bad_y), 64'd1);
            end
    endtask

    task automatic t_multi();
        logic [7:0] masks [4] = '{8'h03, 8'h0C, 8'h11, 8'h50};
        for (int i = 0; i < 4; i++)
            for (int p = 0; p < 8; p++) begin
                apply_manual(masks[i], p);
                check("R4 bad_y", 64'(bad_y), 64'(model_y(masks[i], p)));
                check("R4 good_y", 64'(good_y), 64'(ref_y(p)));
            end
        apply_manual(8'h80, 0);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Entered at the negedge after the accepting edge
    task automatic run_steps(input int poke_at);
        for (int k = 0; k < 64; k++) begin
            check("R5 busy", 64'(busy), 64'd1);
            check("R5 step good_y", 64'(good_y), 64'(ref_y(k % 8)));
            check("R5 step bad_y", 64'(bad_y), 64'(model_y(8'(1 << (k / 8)), k % 8)));
            check("R7 no early done", 64'(done), 64'd0);
            start = (k == poke_at);
            @(negedge clk);
        end
        start = 1'b0;
        check("R7 done", 64'(done), 64'd1);
        check("R7 busy fell", 64'(busy), 64'd0);
        check("R9 done timing", 64'(done), 64'd1);
        check("R6 map", pat_map, expected_map());
        check("R6 hit", 64'(fault_hit), 64'hFF);
        check("R8 count", 64'(hit_count), 64'd8);
    endtask

    task automatic t_sweep();
        pulse_start();
        check("R10 cleared at accept", pat_map, 64'd0);
        run_steps(-1);
        @(negedge clk);
        check("R7 done single cycle", 64'(done), 64'd0);
        check("R6 map held", pat_map, expected_map());
    endtask

    task automatic t_busy_start();
        pulse_start();
        run_steps(10);
        @(negedge clk);
        check("R9 idle after", 64'(busy), 64'd0);
    endtask

    task automatic t_restart_on_done();
        pulse_start();
        run_steps(-1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 restart busy", 64'(busy), 64'd1);
        check("R10 map cleared", pat_map, 64'd0);
        check("R10 hit cleared", 64'(fault_hit), 64'd0);
        check("R10 count cleared", 64'(hit_count), 64'd0);
        check("R7 done dropped", 64'(done), 64'd0);
        run_steps(-1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_single();
        t_multi();
        t_sweep();
        t_busy_start();
        t_restart_on_done();
        finish_run();
    end

endmodule